// File: doc/BRIEF.md
# Iterative Integer Divider with Condition Flags

This block performs integer division for a processor execution stage. A single start strobe presents a dividend, a divisor, the operation mode, signedness, the present N flag and a hint that the quotient and remainder destinations are the same register. The block then grinds out one quotient bit per clock using restoring division on operand magnitudes. It applies the signs at the end and raises a one-cycle done strobe. Along with done it gives the packed result words, one write enable per destination register, the four condition flags and a divide-by-zero indication.

Three operand shapes are supported. Word mode divides a 32-bit dividend by a 16-bit divisor and packs remainder and quotient into one 32-bit word. Long mode divides 32 bits by 32 bits. Quad mode divides a 64-bit dividend, built from two source registers, by a 32-bit divisor. The block checks whether the quotient fits its destination. When it does not, the flags report overflow and no register is written. Fetching operands from the register file and vectoring the exception are left to the surrounding pipeline.

The control is a four-state machine. ST_IDLE waits for start. From there, "accept" moves to ST_CALC when the divisor is nonzero, and "zero-trap" moves straight to ST_DONE when it is zero. ST_CALC stays put on "step" for each quotient bit. "last-step" moves it to ST_PACK, where signs, overflow, packing and flags are evaluated and latched. "publish" moves ST_PACK to ST_DONE, which drives done for one cycle. "retire" then returns to ST_IDLE.

Top module: `iter_divider`

## Requirements
- R1: After reset, done, busy, div_zero, quot_we and rem_we are all low.
- R2: A divisor of zero (only bits 15:0 of divisor count in word mode) produces done with div_zero high on the clock edge that samples start. It asserts neither write enable and gives flag_n equal to n_in with flag_z, flag_v and flag_c low.
- R3: mode 2'b00 is word mode. The divisor is bits 15:0 of divisor, sign-extended when is_signed is high. A result that fits gives quot_out[31:16] = remainder and quot_out[15:0] = quotient, with quot_we high and rem_we low.
- R4: Overflow is declared when the quotient falls outside the destination range: 16 bits in word mode, 32 bits in long and quad modes. The range is unsigned when is_signed is low and two's-complement when it is high.
- R5: On overflow, done comes with flag_v=1, flag_c=0, flag_z=0, flag_n equal to the n_in captured at start, and neither write enable asserted.
- R6: flag_c is low whenever done is high.
- R7: Without overflow, flag_n is the top bit and flag_z the all-zero test of the quotient at the destination width (16 or 32 bits), and flag_v is low.
- R8: mode 2'b10 is quad mode. The dividend is {src_hi, src_lo}, with src_hi as the upper 32 bits.
- R9: mode 2'b01 (and 2'b11, treated the same) is long mode, dividend src_lo. In long and quad modes a fitting result drives quot_out = quotient and rem_out = remainder with quot_we high. rem_we is high only when same_reg is low, so a shared destination keeps the quotient.
- R10: Signed division truncates toward zero, and the remainder takes the sign of the dividend.
- R11: With a nonzero divisor, done rises on the 34th rising edge counting the edge that samples start in word and long modes, and on the 66th in quad mode. done lasts exactly one cycle.
- R12: busy is high from the start edge until done falls. A start pulse while busy is ignored and does not disturb the result in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division (accepted only when idle) |
| mode | input | 2 | 00 word, 01 long, 10 quad, 11 long |
| is_signed | input | 1 | Two's-complement operands when high |
| same_reg | input | 1 | Quotient and remainder destinations coincide |
| n_in | input | 1 | Current N flag, kept on overflow and zero divide |
| src_hi | input | 32 | Upper dividend half (quad mode) |
| src_lo | input | 32 | Dividend (lower half in quad mode) |
| divisor | input | 32 | Divisor (bits 15:0 in word mode) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| div_zero | output | 1 | Divide-by-zero exception, valid with done |
| quot_we | output | 1 | Write enable for the quotient register |
| rem_we | output | 1 | Write enable for the remainder register |
| quot_out | output | 32 | Quotient, or packed remainder:quotient in word mode |
| rem_out | output | 32 | Remainder |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag (always cleared) |

## Verification
The hardest outcomes to reach from the ports are the signed overflow boundaries. The most negative quotient still fits while its positive mirror does not, and in long mode only the most negative dividend divided by minus one overflows. The stimulus aims straight at these: a word-mode quotient of exactly -32768, then +32768, the 32-bit minimum over -1, and a quad-mode quotient of exactly 2^31 from a 64-bit dividend whose upper half is zero. A second start pulse is also injected in the middle of a long computation to show that the accepted operands are held.

// File: rtl/divflags_pkg.sv
package divflags_pkg;

    typedef enum logic [1:0] {
        DM_WORD     = 2'b00,
        DM_LONG     = 2'b01,
        DM_QUAD     = 2'b10,
        DM_LONG_ALT = 2'b11
    } div_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_PACK,
        ST_DONE
    } div_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
    import divflags_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  div_mode_e           mode,
    input  logic                is_signed,
    input  logic [XLEN-1:0]     src_hi,
    input  logic [XLEN-1:0]     src_lo,
    input  logic [XLEN-1:0]     divisor,
    output logic [2*XLEN-1:0]   dividend_mag,
    output logic [XLEN-1:0]     divisor_mag,
    output logic                quot_neg,
    output logic                rem_neg,
    output logic                div_by_zero
);
    localparam int DW   = 2 * XLEN;
    localparam int HALF = XLEN / 2;

    logic [DW-1:0]   num_ext;
    logic [DW-1:0]   num_abs;
    logic            num_sign;
    logic [XLEN-1:0] den_ext;
    logic            den_sign;

    always_comb begin
        if (mode == DM_QUAD) begin
            num_ext = {src_hi, src_lo};
        end else if (is_signed) begin
            num_ext = {{XLEN{src_lo[XLEN-1]}}, src_lo};
        end else begin
            num_ext = {{XLEN{1'b0}}, src_lo};
        end
        num_sign = is_signed & num_ext[DW-1];
        num_abs  = num_sign ? (~num_ext + 1'b1) : num_ext;
        // 32-bit dividends are pre-aligned so that XLEN shifts finish the job
        if (mode == DM_QUAD) begin
            dividend_mag = num_abs;
        end else begin
            dividend_mag = {num_abs[XLEN-1:0], {XLEN{1'b0}}};
        end

        if (mode == DM_WORD) begin
            den_ext = is_signed ? {{HALF{divisor[HALF-1]}}, divisor[HALF-1:0]}
                                : {{HALF{1'b0}}, divisor[HALF-1:0]};
        end else begin
            den_ext = divisor;
        end
        den_sign    = is_signed & den_ext[XLEN-1];
        divisor_mag = den_sign ? (~den_ext + 1'b1) : den_ext;

        div_by_zero = (den_ext == '0);
        quot_neg    = num_sign ^ den_sign;
        rem_neg     = num_sign;
    end
endmodule

// File: rtl/div_restoring_core.sv
module div_restoring_core #(
    parameter int XLEN = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  logic [2*XLEN-1:0]   dividend_mag,
    input  logic [XLEN-1:0]     divisor_mag,
    output logic [2*XLEN-1:0]   quot_mag,
    output logic [XLEN-1:0]     rem_mag
);
    localparam int DW = 2 * XLEN;

    logic [DW-1:0]   q_r;
    logic [XLEN-1:0] r_r;
    logic [XLEN-1:0] d_r;
    logic [XLEN:0]   trial;
    logic [XLEN:0]   diff;
    logic            fits;

    always_comb begin
        trial = {r_r, q_r[DW-1]};
        diff  = trial - {1'b0, d_r};
        fits  = ~diff[XLEN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= '0;
            r_r <= '0;
            d_r <= '0;
        end else if (load) begin
            q_r <= dividend_mag;
            r_r <= '0;
            d_r <= divisor_mag;
        end else if (step) begin
            q_r <= {q_r[DW-2:0], fits};
            r_r <= fits ? diff[XLEN-1:0] : trial[XLEN-1:0];
        end
    end

    assign quot_mag = q_r;
    assign rem_mag  = r_r;

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (r_r < d_r)); // R10
endmodule

// File: rtl/div_result_pack.sv
module div_result_pack
    import divflags_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  div_mode_e           mode,
    input  logic                is_signed,
    input  logic                same_reg,
    input  logic                n_keep,
    input  logic                quot_neg,
    input  logic                rem_neg,
    input  logic [2*XLEN-1:0]   quot_mag,
    input  logic [XLEN-1:0]     rem_mag,
    output logic [XLEN-1:0]     quot_word,
    output logic [XLEN-1:0]     rem_word,
    output logic                quot_wr,
    output logic                rem_wr,
    output logic                overflow,
    output ccr_t                ccr
);
    localparam int DW   = 2 * XLEN;
    localparam int HALF = XLEN / 2;
    localparam logic [DW-1:0] ONE       = 1;
    localparam logic [DW-1:0] U_LIM_H   = (ONE << HALF) - ONE;
    localparam logic [DW-1:0] U_LIM_F   = (ONE << XLEN) - ONE;
    localparam logic [DW-1:0] SPOS_LIM_H = (ONE << (HALF - 1)) - ONE;
    localparam logic [DW-1:0] SNEG_LIM_H = ONE << (HALF - 1);
    localparam logic [DW-1:0] SPOS_LIM_F = (ONE << (XLEN - 1)) - ONE;
    localparam logic [DW-1:0] SNEG_LIM_F = ONE << (XLEN - 1);

    logic            is_word;
    logic [DW-1:0]   limit;
    logic [DW-1:0]   q_val;
    logic [XLEN-1:0] r_val;

    always_comb begin
        is_word = (mode == DM_WORD);
        if (!is_signed) begin
            limit = is_word ? U_LIM_H : U_LIM_F;
        end else if (quot_neg) begin
            limit = is_word ? SNEG_LIM_H : SNEG_LIM_F;
        end else begin
            limit = is_word ? SPOS_LIM_H : SPOS_LIM_F;
        end
        overflow = (quot_mag > limit);

        q_val = quot_neg ? (~quot_mag + 1'b1) : quot_mag;
        r_val = rem_neg ? (~rem_mag + 1'b1) : rem_mag;

        rem_word = r_val;
        if (is_word) begin
            quot_word = {r_val[HALF-1:0], q_val[HALF-1:0]};
            ccr.n     = q_val[HALF-1];
            ccr.z     = (q_val[HALF-1:0] == '0);
        end else begin
            quot_word = q_val[XLEN-1:0];
            ccr.n     = q_val[XLEN-1];
            ccr.z     = (q_val[XLEN-1:0] == '0);
        end
        ccr.v = 1'b0;
        ccr.c = 1'b0;
        quot_wr = 1'b1;
        rem_wr  = !is_word && !same_reg;

        if (overflow) begin
            ccr     = '{n: n_keep, z: 1'b0, v: 1'b1, c: 1'b0};
            quot_wr = 1'b0;
            rem_wr  = 1'b0;
        end
    end
endmodule

// File: rtl/iter_divider.sv
module iter_divider
    import divflags_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      mode,
    input  logic            is_signed,
    input  logic            same_reg,
    input  logic            n_in,
    input  logic [XLEN-1:0] src_hi,
    input  logic [XLEN-1:0] src_lo,
    input  logic [XLEN-1:0] divisor,
    output logic            busy,
    output logic            done,
    output logic            div_zero,
    output logic            quot_we,
    output logic            rem_we,
    output logic [XLEN-1:0] quot_out,
    output logic [XLEN-1:0] rem_out,
    output logic            flag_n,
    output logic            flag_z,
    output logic            flag_v,
    output logic            flag_c
);
    localparam int DW    = 2 * XLEN;
    localparam int CNT_W = $clog2(DW);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(XLEN - 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DW - 1);

    div_state_e state_q, state_d;
    div_mode_e  mode_in, mode_q;

    logic sgn_q, same_q, nin_q, qneg_q, rneg_q, dz_q;
    logic [CNT_W-1:0] cnt_q, last_q;
    logic qwe_q, rwe_q;
    logic [XLEN-1:0] quot_q, rem_q;
    ccr_t ccr_q;

    logic [DW-1:0]   prep_dividend;
    logic [XLEN-1:0] prep_divisor;
    logic            prep_qneg, prep_rneg, prep_dz;
    logic [DW-1:0]   core_quot;
    logic [XLEN-1:0] core_rem;
    logic [XLEN-1:0] pk_quot, pk_rem;
    logic            pk_qwe, pk_rwe, pk_ovf;
    ccr_t            pk_ccr;
    logic            accept;

    assign mode_in = div_mode_e'(mode);
    assign accept  = (state_q == ST_IDLE) && start;

    div_operand_prep #(.XLEN(XLEN)) u_prep (
        .mode         (mode_in),
        .is_signed    (is_signed),
        .src_hi       (src_hi),
        .src_lo       (src_lo),
        .divisor      (divisor),
        .dividend_mag (prep_dividend),
        .divisor_mag  (prep_divisor),
        .quot_neg     (prep_qneg),
        .rem_neg      (prep_rneg),
        .div_by_zero  (prep_dz)
    );

    div_restoring_core #(.XLEN(XLEN)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (accept && !prep_dz),
        .step         (state_q == ST_CALC),
        .dividend_mag (prep_dividend),
        .divisor_mag  (prep_divisor),
        .quot_mag     (core_quot),
        .rem_mag      (core_rem)
    );

    div_result_pack #(.XLEN(XLEN)) u_pack (
        .mode      (mode_q),
        .is_signed (sgn_q),
        .same_reg  (same_q),
        .n_keep    (nin_q),
        .quot_neg  (qneg_q),
        .rem_neg   (rneg_q),
        .quot_mag  (core_quot),
        .rem_mag   (core_rem),
        .quot_word (pk_quot),
        .rem_word  (pk_rem),
        .quot_wr   (pk_qwe),
        .rem_wr    (pk_rwe),
        .overflow  (pk_ovf),
        .ccr       (pk_ccr)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = prep_dz ? ST_DONE : ST_CALC;
            ST_CALC: if (cnt_q == last_q) state_d = ST_PACK;
            ST_PACK: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= DM_WORD;
            sgn_q  <= 1'b0;
            same_q <= 1'b0;
            nin_q  <= 1'b0;
            qneg_q <= 1'b0;
            rneg_q <= 1'b0;
            dz_q   <= 1'b0;
            cnt_q  <= '0;
            last_q <= '0;
            qwe_q  <= 1'b0;
            rwe_q  <= 1'b0;
            quot_q <= '0;
            rem_q  <= '0;
            ccr_q  <= '0;
        end else begin
            if (accept) begin
                mode_q <= mode_in;
                sgn_q  <= is_signed;
                same_q <= same_reg;
                nin_q  <= n_in;
                qneg_q <= prep_qneg;
                rneg_q <= prep_rneg;
                dz_q   <= prep_dz;
                cnt_q  <= '0;
                last_q <= (mode_in == DM_QUAD) ? LAST_LONG : LAST_SHORT;
                qwe_q  <= 1'b0;
                rwe_q  <= 1'b0;
                ccr_q  <= '{n: n_in, z: 1'b0, v: 1'b0, c: 1'b0};
            end
            if (state_q == ST_CALC) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == ST_PACK) begin
                qwe_q  <= pk_qwe;
                rwe_q  <= pk_rwe;
                quot_q <= pk_quot;
                rem_q  <= pk_rem;
                ccr_q  <= pk_ccr;
            end
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_DONE);
    assign div_zero = done && dz_q;
    assign quot_we  = done && qwe_q;
    assign rem_we   = done && rwe_q;
    assign quot_out = quot_q;
    assign rem_out  = rem_q;
    assign flag_n   = ccr_q.n;
    assign flag_z   = ccr_q.z;
    assign flag_v   = ccr_q.v;
    assign flag_c   = ccr_q.c;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_OVF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_v) |-> (!quot_we && !rem_we && !flag_z)); // R5
    AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !flag_c); // R6
    AST_DZ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> (!quot_we && !rem_we)); // R2
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R12
endmodule

// File: tb/iter_divider_tb.sv
`timescale 1ns/1ps
module iter_divider_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        is_signed = 1'b0;
    logic        same_reg = 1'b0;
    logic        n_in = 1'b0;
    logic [31:0] src_hi = '0;
    logic [31:0] src_lo = '0;
    logic [31:0] divisor = '0;
    logic        busy, done, div_zero, quot_we, rem_we;
    logic [31:0] quot_out, rem_out;
    logic        flag_n, flag_z, flag_v, flag_c;

    int n_checks = 0;
    int n_fail = 0;

    logic [31:0] e_quot, e_rem;
    logic        e_qwe, e_rwe, e_dz, e_n, e_z, e_v;
    int          e_lat;

    always #2 clk = ~clk;

    iter_divider u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .is_signed(is_signed), .same_reg(same_reg), .n_in(n_in),
        .src_hi(src_hi), .src_lo(src_lo), .divisor(divisor),
        .busy(busy), .done(done), .div_zero(div_zero),
        .quot_we(quot_we), .rem_we(rem_we),
        .quot_out(quot_out), .rem_out(rem_out),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void calc_expect(input logic [1:0] md, input logic sg,
        input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] dv,
        input logic same, input logic nin);
        logic signed [95:0] num, den, q, r, hi_lim, lo_lim;
        logic signed [95:0] one;
        int w;
        logic ovf;
        one = 96'sd1;
        w = (md == 2'b00) ? 16 : 32;
        if (md == 2'b10) num = sg ? {{32{hi[31]}}, hi, lo} : {32'b0, hi, lo};
        else             num = sg ? {{64{lo[31]}}, lo} : {64'b0, lo};
        if (md == 2'b00) den = sg ? {{80{dv[15]}}, dv[15:0]} : {80'b0, dv[15:0]};
        else             den = sg ? {{64{dv[31]}}, dv} : {64'b0, dv};
        e_dz = (den == 0);
        e_quot = '0; e_rem = '0; e_qwe = 0; e_rwe = 0;
        e_n = nin; e_z = 0; e_v = 0;
        e_lat = e_dz ? 1 : ((md == 2'b10) ? 66 : 34);
        if (!e_dz) begin
            q = num / den;
            r = num % den;
            hi_lim = sg ? ((one <<< (w - 1)) - one) : ((one <<< w) - one);
            lo_lim = sg ? -(one <<< (w - 1)) : 96'sd0;
            ovf = (q > hi_lim) || (q < lo_lim);
            if (ovf) begin
                e_v = 1;
            end else if (md == 2'b00) begin
                e_quot = {r[15:0], q[15:0]};
                e_qwe = 1;
                e_n = q[15];
                e_z = (q[15:0] == 16'h0);
            end else begin
                e_quot = q[31:0];
                e_rem = r[31:0];
                e_qwe = 1;
                e_rwe = !same;
                e_n = q[31];
                e_z = (q[31:0] == 32'h0);
            end
        end
    endfunction

    task automatic drive(input logic [1:0] md, input logic sg, input logic [31:0] hi,
                         input logic [31:0] lo, input logic [31:0] dv,
                         input logic same, input logic nin);
        mode = md; is_signed = sg; src_hi = hi; src_lo = lo;
        divisor = dv; same_reg = same; n_in = nin;
    endtask

    task automatic check_result(input string tag, input int cyc);
        chk("R11", "latency", 64'(cyc), 64'(e_lat));
        chk(tag, "done", {63'b0, done}, {63'b0, 1'b1});
        chk(tag, "div_zero", {63'b0, div_zero}, {63'b0, e_dz});
        chk(tag, "quot_we", {63'b0, quot_we}, {63'b0, e_qwe});
        chk(tag, "rem_we", {63'b0, rem_we}, {63'b0, e_rwe});
        chk(tag, "flag_n", {63'b0, flag_n}, {63'b0, e_n});
        chk(tag, "flag_z", {63'b0, flag_z}, {63'b0, e_z});
        chk(tag, "flag_v", {63'b0, flag_v}, {63'b0, e_v});
        chk("R6", "flag_c", {63'b0, flag_c}, 64'd0);
        if (e_qwe) chk(tag, "quot_out", {32'b0, quot_out}, {32'b0, e_quot});
        if (e_rwe) chk(tag, "rem_out", {32'b0, rem_out}, {32'b0, e_rem});
        @(posedge clk); #1;
        chk("R11", "done single cycle", {63'b0, done}, 64'd0);
    endtask

    task automatic run_div(input string tag, input logic [1:0] md, input logic sg,
                           input logic [31:0] hi, input logic [31:0] lo,
                           input logic [31:0] dv, input logic same, input logic nin);
        int cyc;
        calc_expect(md, sg, hi, lo, dv, same, nin);
        @(negedge clk);
        drive(md, sg, hi, lo, dv, same, nin);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 100) begin
            @(posedge clk); #1;
            cyc++;
        end
        check_result(tag, cyc);
    endtask

    task automatic t_reset;
        chk("R1", "done", {63'b0, done}, 64'd0);
        chk("R1", "busy", {63'b0, busy}, 64'd0);
        chk("R1", "div_zero", {63'b0, div_zero}, 64'd0);
        chk("R1", "we", {62'b0, quot_we, rem_we}, 64'd0);
    endtask

    task automatic t_word;
        run_div("R3", 2'b00, 1'b0, 32'h0, 32'd100000, 32'd7, 1'b0, 1'b0);
        run_div("R7", 2'b00, 1'b0, 32'h0, 32'd3, 32'd7, 1'b0, 1'b1);
        run_div("R10", 2'b00, 1'b1, 32'h0, -32'sd100, 32'd7, 1'b0, 1'b0);
        run_div("R10", 2'b00, 1'b1, 32'h0, 32'd100, 32'h1234FFF9, 1'b0, 1'b0);
    endtask

    task automatic t_overflow;
        run_div("R5", 2'b00, 1'b0, 32'h0, 32'h12345678, 32'd2, 1'b0, 1'b1);
        run_div("R4", 2'b00, 1'b1, 32'h0, 32'hFFFF0000, 32'd2, 1'b0, 1'b0);
        run_div("R4", 2'b00, 1'b1, 32'h0, 32'h00010000, 32'd2, 1'b0, 1'b0);
        run_div("R5", 2'b01, 1'b1, 32'h0, 32'h80000000, 32'hFFFFFFFF, 1'b0, 1'b1);
        run_div("R4", 2'b10, 1'b0, 32'd2, 32'h0, 32'd2, 1'b0, 1'b0);
        run_div("R4", 2'b10, 1'b1, 32'h0, 32'h80000000, 32'd1, 1'b0, 1'b1);
    endtask

    task automatic t_long;
        run_div("R9", 2'b01, 1'b0, 32'h0, 32'hFFFFFFFF, 32'd16, 1'b0, 1'b0);
        run_div("R9", 2'b01, 1'b0, 32'h0, 32'd1000, 32'd7, 1'b1, 1'b0);
        run_div("R9", 2'b11, 1'b0, 32'h0, 32'd1000, 32'd7, 1'b0, 1'b1);
        run_div("R10", 2'b01, 1'b1, 32'h0, -32'sd7, 32'd2, 1'b0, 1'b0);
    endtask

    task automatic t_quad;
        run_div("R8", 2'b10, 1'b0, 32'd1, 32'h0, 32'd2, 1'b0, 1'b0);
        run_div("R8", 2'b10, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFF9, 32'd2, 1'b0, 1'b0);
        run_div("R8", 2'b10, 1'b0, 32'h00000003, 32'h89ABCDEF, 32'h00012345, 1'b0, 1'b1);
    endtask

    task automatic t_divzero;
        run_div("R2", 2'b00, 1'b1, 32'h0, 32'd55, 32'h00010000, 1'b0, 1'b1);
        run_div("R2", 2'b01, 1'b0, 32'h0, 32'd55, 32'h0, 1'b0, 1'b0);
        run_div("R2", 2'b10, 1'b1, 32'd9, 32'd55, 32'h0, 1'b0, 1'b1);
    endtask

    task automatic t_busy_ignore;
        int cyc;
        calc_expect(2'b01, 1'b0, 32'h0, 32'd1000, 32'd10, 1'b0, 1'b0);
        @(negedge clk);
        drive(2'b01, 1'b0, 32'h0, 32'd1000, 32'd10, 1'b0, 1'b0);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        cyc = 1;
        repeat (5) begin @(posedge clk); #1; cyc++; end
        chk("R12", "busy mid-run", {63'b0, busy}, 64'd1);
        drive(2'b00, 1'b0, 32'h0, 32'd7, 32'd0, 1'b1, 1'b1);
        start = 1'b1;
        @(posedge clk); #1;
        cyc++;
        start = 1'b0;
        drive(2'b01, 1'b0, 32'h0, 32'd1000, 32'd10, 1'b0, 1'b0);
        while (!done && cyc < 100) begin
            @(posedge clk); #1;
            cyc++;
        end
        check_result("R12", cyc);
    endtask

    initial begin
        #(4.0 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_word();
        t_overflow();
        t_long();
        t_quad();
        t_divzero();
        t_busy_ignore();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule